// File: doc/BRIEF.md
# Two-Input Arbitrated Merge with Source Tag

This block joins two valid/ready token streams into one. Whenever at least one input holds a token, a round-robin arbiter chooses an input. The chosen token's payload appears on a data output channel. At the same time, a separate tag output channel reports which input supplied it. A consumer on the tag channel, typically a demultiplexer, can therefore send results back to the correct requester. This lets two producers share one downstream resource safely.

The data and tag outputs behave as an eager two-way fork. Each output carries its own "already delivered" flag, so either channel may complete before the other. The winning input is acknowledged only once both channels have transferred the token. From the first cycle a token is offered until that input is consumed, the arbiter's choice stays frozen.

Back-pressure rules on every channel: a transfer happens in a cycle where valid and ready are both 1. A sender that raises valid keeps valid and its payload unchanged until that transfer happens. Ready may depend combinationally on valid. No output valid depends combinationally on any output ready.

Top module: `tagged_merge2`

## Requirements
- R1: After reset, with both inputs idle, `out_valid`, `tag_valid`, `a_ready` and `b_ready` are all 0.
- R2: While `out_valid` is 1, `out_data` equals the payload of the chosen input.
- R3: `tag_idx` is 0 when input a supplied the token and 1 when input b supplied it. In delivery order, the k-th data token matches the k-th tag.
- R4: Every accepted input token is delivered exactly once on the data channel and exactly once on the tag channel. After a channel transfers, its valid stays 0 until the input is consumed, while the other channel may still be pending.
- R5: An input's ready is 1 only for the chosen input, only while it is valid, and only in a cycle where both output channels have transferred (in that cycle or earlier). At most one input ready is 1.
- R6: From the first cycle a token is offered until its input is consumed, the chosen input does not change, even if the other input becomes valid.
- R7: When both inputs are valid at a fresh decision, the input that was not served last wins. Input a has priority first after reset. With both inputs always valid and both outputs always ready, the tags alternate 0,1,0,1.
- R8: `out_valid` and `tag_valid` do not change when `out_ready` or `tag_ready` change within a cycle.
- R9: A channel whose valid is 1 while its ready is 0 keeps valid at 1 and its payload (data or tag) unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_valid | input | 1 | Input a token present |
| a_ready | output | 1 | Input a token consumed |
| a_data | input | DATA_W | Input a payload |
| b_valid | input | 1 | Input b token present |
| b_ready | output | 1 | Input b token consumed |
| b_data | input | DATA_W | Input b payload |
| out_valid | output | 1 | Data output token present |
| out_ready | input | 1 | Data output accepted |
| out_data | output | DATA_W | Forwarded payload |
| tag_valid | output | 1 | Tag output token present |
| tag_ready | input | 1 | Tag output accepted |
| tag_idx | output | 1 | Index of the supplying input (a=0, b=1) |

## Verification
The hold and no-duplicate properties assume that each producer keeps valid and payload stable from assertion until its ready is seen. Without that, a locked choice could point at an input that has gone away. The bench producers honour this: they pick a new payload only after a consumed handshake and never drop valid early. Ready on the output side may toggle freely, including within a cycle, because the block makes no assumption about consumers.

// File: rtl/tmerge_pkg.sv
package tmerge_pkg;
  localparam int unsigned SRC_CNT = 2;
  localparam int unsigned SRC_W   = $clog2(SRC_CNT);
  localparam int unsigned LEG_CNT = 2;

  typedef logic [SRC_W-1:0] src_idx_t;

  localparam src_idx_t SRC_A = src_idx_t'(0);
  localparam src_idx_t SRC_B = src_idx_t'(1);

  localparam int unsigned LEG_DATA = 0;
  localparam int unsigned LEG_TAG  = 1;
endpackage

// File: rtl/rr_lock_pick.sv
// Round-robin chooser that freezes its choice from the first offer
// until the chosen requester is consumed.
module rr_lock_pick #(
  parameter int unsigned N  = 2,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          consume,
  output logic [IW-1:0] grant,
  output logic          have
);
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] held_q;
  logic          locked_q;
  logic [IW-1:0] rr_idx;
  logic [IW-1:0] next_ptr;

  // scan from the pointer upward; the lowest offset that requests wins
  always_comb begin
    rr_idx = ptr_q;
    for (int k = N - 1; k >= 0; k--) begin
      int unsigned pos;
      pos = (int'(ptr_q) + k) % N;
      if (req[pos]) rr_idx = IW'(pos);
    end
  end

  assign grant    = locked_q ? held_q : rr_idx;
  assign have     = req[grant];
  assign next_ptr = IW'((int'(grant) + 1) % N);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      held_q   <= '0;
      locked_q <= 1'b0;
    end else if (consume) begin
      locked_q <= 1'b0;
      ptr_q    <= next_ptr;
    end else if (have && !locked_q) begin
      locked_q <= 1'b1;
      held_q   <= rr_idx;
    end
  end
endmodule

// File: rtl/fork_leg.sv
// One output of an eager fork: offers once, remembers delivery.
module fork_leg (
  input  logic clk,
  input  logic rst_n,
  input  logic offer,
  input  logic take,
  input  logic clear,
  output logic valid,
  output logic finished
);
  logic sent_q;
  logic fire;

  assign valid    = offer & ~sent_q;
  assign fire     = valid & take;
  assign finished = sent_q | fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sent_q <= 1'b0;
    else if (clear) sent_q <= 1'b0;
    else if (fire)  sent_q <= 1'b1;
  end
endmodule

// File: rtl/payload_sel.sv
module payload_sel #(
  parameter int unsigned N  = 2,
  parameter int unsigned W  = 16,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*W-1:0] flat,
  input  logic [IW-1:0]  sel,
  output logic [W-1:0]   out
);
  always_comb begin
    out = flat[W-1:0];
    for (int i = 0; i < N; i++) begin
      if (sel == IW'(i)) out = flat[i*W +: W];
    end
  end
endmodule

// File: rtl/tagged_merge2.sv
module tagged_merge2
  import tmerge_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_valid,
  output logic              a_ready,
  input  logic [DATA_W-1:0] a_data,
  input  logic              b_valid,
  output logic              b_ready,
  input  logic [DATA_W-1:0] b_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              tag_valid,
  input  logic              tag_ready,
  output logic              tag_idx
);
  logic [SRC_CNT-1:0]        src_valid;
  logic [SRC_CNT-1:0]        src_ready;
  logic [SRC_CNT*DATA_W-1:0] src_flat;
  src_idx_t                  grant;
  logic                      have;
  logic                      all_done;
  logic                      consume;
  logic [LEG_CNT-1:0]        leg_take;
  logic [LEG_CNT-1:0]        leg_valid;
  logic [LEG_CNT-1:0]        leg_fin;

  assign src_valid = {b_valid, a_valid};
  assign src_flat  = {b_data, a_data};

  rr_lock_pick #(.N(SRC_CNT), .IW(SRC_W)) picker_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (src_valid),
    .consume (consume),
    .grant   (grant),
    .have    (have)
  );

  payload_sel #(.N(SRC_CNT), .W(DATA_W), .IW(SRC_W)) mux_i (
    .flat (src_flat),
    .sel  (grant),
    .out  (out_data)
  );

  assign leg_take[LEG_DATA] = out_ready;
  assign leg_take[LEG_TAG]  = tag_ready;

  generate
    for (genvar g = 0; g < LEG_CNT; g++) begin : g_leg
      fork_leg leg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .offer    (have),
        .take     (leg_take[g]),
        .clear    (consume),
        .valid    (leg_valid[g]),
        .finished (leg_fin[g])
      );
    end
  endgenerate

  assign all_done = &leg_fin;
  assign consume  = have & all_done;

  generate
    for (genvar s = 0; s < SRC_CNT; s++) begin : g_rdy
      assign src_ready[s] = consume & (grant == src_idx_t'(s));
    end
  endgenerate

  assign a_ready   = src_ready[SRC_A];
  assign b_ready   = src_ready[SRC_B];
  assign out_valid = leg_valid[LEG_DATA];
  assign tag_valid = leg_valid[LEG_TAG];
  assign tag_idx   = grant[0];
endmodule

// File: rtl/tagged_merge2_chk.sv
module tagged_merge2_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_valid,
  input logic              a_ready,
  input logic              b_valid,
  input logic              b_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              tag_valid,
  input logic              tag_ready,
  input logic              tag_idx
);
  logic took_in;
  logic d_done_q;
  logic t_done_q;

  assign took_in = (a_valid && a_ready) || (b_valid && b_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_done_q <= 1'b0;
      t_done_q <= 1'b0;
    end else if (took_in) begin
      d_done_q <= 1'b0;
      t_done_q <= 1'b0;
    end else begin
      if (out_valid && out_ready) d_done_q <= 1'b1;
      if (tag_valid && tag_ready) t_done_q <= 1'b1;
    end
  end

  assert_one_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_ready, b_ready}));

  assert_ready_a_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    a_ready |-> a_valid);

  assert_ready_b_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    b_ready |-> b_valid);

  assert_consume_after_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    took_in |-> ((d_done_q || (out_valid && out_ready)) &&
                 (t_done_q || (tag_valid && tag_ready))));

  assert_no_dup_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    d_done_q |-> !out_valid);

  assert_no_dup_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    t_done_q |-> !tag_valid);

  assert_tag_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ready && tag_valid) |-> (tag_idx == 1'b0));

  assert_tag_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (b_ready && tag_valid) |-> (tag_idx == 1'b1));

  assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_tag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid && !tag_ready) |=> (tag_valid && $stable(tag_idx)));
endmodule

bind tagged_merge2 tagged_merge2_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .a_valid   (a_valid),
  .a_ready   (a_ready),
  .b_valid   (b_valid),
  .b_ready   (b_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .tag_valid (tag_valid),
  .tag_ready (tag_ready),
  .tag_idx   (tag_idx)
);

// File: tb/tagged_merge2_tb_top.sv
`timescale 1ns/100ps
module tagged_merge2_tb_top;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          a_valid = 1'b0, b_valid = 1'b0;
  logic [DW-1:0] a_data = '0, b_data = '0;
  logic          a_ready, b_ready;
  logic          out_valid, tag_valid, tag_idx;
  logic [DW-1:0] out_data;
  logic          out_ready = 1'b0, tag_ready = 1'b0;

  int checks = 0;
  int errors = 0;

  // producer / consumer modes: 0 off, 1 always, 2 random
  int a_mode = 0, b_mode = 0, o_mode = 0, t_mode = 0;
  int gen_a = 0, gen_b = 0;
  bit a_took = 0, b_took = 0;

  logic [DW-1:0] cons_a[$], cons_b[$], got_d[$];
  bit            got_t[$];

  // behavioural reference state
  bit m_busy = 0, m_src = 0, m_dsent = 0, m_tsent = 0, m_prio = 0;

  always #2.5 clk = ~clk;

  tagged_merge2 #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .tag_valid(tag_valid), .tag_ready(tag_ready), .tag_idx(tag_idx)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit want(input int mode);
    if (mode == 1) return 1'b1;
    if (mode == 2) return 1'($urandom_range(0, 1));
    return 1'b0;
  endfunction

  // stimulus driver: acts just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (a_took) a_valid = 1'b0;
      if (b_took) b_valid = 1'b0;
      if (!a_valid && rst_n && want(a_mode)) begin
        a_valid = 1'b1; a_data = DW'(16'hA000 + gen_a); gen_a++;
      end
      if (!b_valid && rst_n && want(b_mode)) begin
        b_valid = 1'b1; b_data = DW'(16'hB000 + gen_b); gen_b++;
      end
      out_ready = want(o_mode);
      tag_ready = want(t_mode);
    end
  end

  // reference model, compared at every falling edge
  always @(negedge clk) begin
    bit g, have, e_ov, e_tv, fd, ft, done, e_ar, e_br;
    if (!rst_n) begin
      m_busy = 0; m_dsent = 0; m_tsent = 0; m_prio = 0; m_src = 0;
      a_took = 0; b_took = 0;
    end else begin
      if (m_busy)                g = m_src;
      else if (a_valid && b_valid) g = m_prio;
      else if (a_valid)          g = 1'b0;
      else                       g = 1'b1;
      have = m_busy || a_valid || b_valid;
      e_ov = have && !m_dsent;
      e_tv = have && !m_tsent;
      fd   = e_ov && out_ready;
      ft   = e_tv && tag_ready;
      done = have && (m_dsent || fd) && (m_tsent || ft);
      e_ar = done && !g;
      e_br = done && g;
      chk(out_valid == e_ov, "R4", "out_valid", out_valid, e_ov);
      chk(tag_valid == e_tv, "R4", "tag_valid", tag_valid, e_tv);
      if (e_ov) chk(out_data == (g ? b_data : a_data), "R2", "out_data",
                    out_data, g ? b_data : a_data);
      if (e_tv) chk(tag_idx == g, "R3", "tag_idx", tag_idx, g);
      chk(a_ready == e_ar, "R5", "a_ready", a_ready, e_ar);
      chk(b_ready == e_br, "R5", "b_ready", b_ready, e_br);
      if (out_valid && out_ready) got_d.push_back(out_data);
      if (tag_valid && tag_ready) got_t.push_back(tag_idx);
      a_took = a_valid && a_ready;
      b_took = b_valid && b_ready;
      if (a_took) cons_a.push_back(a_data);
      if (b_took) cons_b.push_back(b_data);
      if (done) begin
        m_busy = 0; m_dsent = 0; m_tsent = 0; m_prio = !g;
      end else if (have) begin
        m_busy = 1; m_src = g;
        m_dsent = m_dsent || fd;
        m_tsent = m_tsent || ft;
      end
    end
  end

  task automatic summary_and_end();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    summary_and_end();
  end

  // within one cycle, toggle a ready and watch the valids (R8)
  task automatic ready_probe();
    bit ov0, tv0, ov1, tv1, so, st;
    @(posedge clk);
    #1.5;
    so = out_ready; st = tag_ready;
    out_ready = 1'b0; tag_ready = 1'b0;
    #0.2; ov0 = out_valid; tv0 = tag_valid;
    out_ready = 1'b1; tag_ready = 1'b1;
    #0.2; ov1 = out_valid; tv1 = tag_valid;
    out_ready = so; tag_ready = st;
    chk(ov0 == ov1, "R8", "out_valid vs ready", ov1, ov0);
    chk(tv0 == tv1, "R8", "tag_valid vs ready", tv1, tv0);
  endtask

  task automatic drain();
    a_mode = 0; b_mode = 0; o_mode = 1; t_mode = 1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    logic [DW-1:0] d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #0.1;
    // R1: idle after reset
    chk(!out_valid && !tag_valid, "R1", "valids idle", {out_valid, tag_valid}, 0);
    chk(!a_ready && !b_ready, "R1", "readies idle", {a_ready, b_ready}, 0);

    // R7: saturated inputs, tags alternate starting from a
    a_mode = 1; b_mode = 1; o_mode = 1; t_mode = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #0.1;
      chk(tag_idx == 1'(i % 2), "R7", "alternation", tag_idx, i % 2);
    end
    drain();

    // R6/R9/R4: data stalled, tag delivered, other input arrives
    a_mode = 1; o_mode = 0; t_mode = 1;
    @(negedge clk); #0.1;
    d0 = out_data;
    chk(out_valid && tag_valid && tag_idx == 1'b0, "R6", "a offered",
        {out_valid, tag_valid, tag_idx}, 3'b110);
    a_mode = 0; b_mode = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #0.1;
      chk(out_valid && out_data == d0, "R9", "stalled data held", out_data, d0);
      chk(!tag_valid, "R4", "tag not repeated", tag_valid, 0);
      chk(!a_ready && !b_ready, "R6", "choice frozen", {a_ready, b_ready}, 0);
    end
    o_mode = 1;
    @(negedge clk); #0.1;
    chk(a_ready && !b_ready, "R5", "a consumed on last leg", {a_ready, b_ready}, 2'b10);
    @(negedge clk); #0.1;
    chk(tag_valid && tag_idx == 1'b1, "R7", "b served next", tag_idx, 1);
    drain();

    // random traffic with independent back-pressure
    a_mode = 2; b_mode = 2; o_mode = 2; t_mode = 2;
    for (int i = 0; i < 40; i++) begin
      repeat (20) @(negedge clk);
      ready_probe();
    end
    // data always ready, tag random
    o_mode = 1;
    repeat (300) @(negedge clk);
    drain();
    repeat (4) @(negedge clk);

    // R4/R3: exactly-once delivery and tag/data pairing
    chk(cons_a.size() == gen_a, "R4", "a tokens consumed", cons_a.size(), gen_a);
    chk(cons_b.size() == gen_b, "R4", "b tokens consumed", cons_b.size(), gen_b);
    chk(got_d.size() == gen_a + gen_b, "R4", "data deliveries", got_d.size(), gen_a + gen_b);
    chk(got_t.size() == got_d.size(), "R4", "tag deliveries", got_t.size(), got_d.size());
    for (int k = 0; k < got_d.size() && k < got_t.size(); k++) begin
      logic [DW-1:0] e;
      if (got_t[k]) e = (cons_b.size() > 0) ? cons_b.pop_front() : '1;
      else          e = (cons_a.size() > 0) ? cons_a.pop_front() : '1;
      chk(got_d[k] == e, "R3", "data matches tag source", got_d[k], e);
    end
    summary_and_end();
  end
endmodule